// File: doc/BRIEF.md
# Byte-Addressed GPIO Controller with Interrupt Lines

This block is a general-purpose I/O controller that sits on a byte-wide register bus. It keeps one control byte for each of 36 pins and has a bank of 8 level bytes that software can only read. In each control byte, bit 2 enables the output, bit 1 holds the sampled input level and bit 0 holds the output value. Software sets the output-enable and output-value bits through bus writes. The input bit changes when the pin side reports a new level. When a pin is driven as an output, a bus write also copies its output value into the input bit.

Two pins feed interrupt lines. Pin 1 drives a level-low source: its line is asserted while the pin reads 0. Pin 9 drives a line that follows its input high, so that a downstream controller can detect edges on it. A one-cycle non-maskable request raises pin 9 for exactly one clock and then drops it, which gives a single pulse on that line. The interrupt lines are registered. They move only when a pin-level update actually changes the pin's byte, or when the non-maskable request acts on pin 9. A pin-level update aimed at a pin that is configured as an output is still applied, and it raises a one-cycle error flag.

Top module: `gpio_byte_ctrl`

## Requirements
- R1: During and after synchronous reset, every control byte reads 0x00, except pin 1, which reads 0x02 (input bit set). Both interrupt outputs and the error flag are 0.
- R2: Reads are combinational in the same cycle. Offsets 0 to 7 return 0x00. Offsets 8 to 43 return the control byte of pin (offset - 8). Offsets 44 to 63 return 0x00.
- R3: A write to offsets 0 to 7 or 44 to 63 changes no control byte and no output.
- R4: A write to a pin offset stores data bits 7:3, bit 2 and bit 0 as written, and discards data bit 1. If data bit 2 is 1, the stored bit 1 becomes data bit 0. Otherwise the stored bit 1 keeps its old value. The new byte can be read from the next cycle.
- R5: A pin-level update with index below 36 replaces only bit 1 of that pin's byte. An update with index 36 or higher is ignored. When a bus write and an update hit the same pin in the same cycle, the write is applied first and the update then sets bit 1.
- R6: When an update changes pin 1's byte, `irq_lowlvl` becomes the inverse of the new level in the next cycle.
- R7: When an update changes pin 9's byte, `irq_follow` becomes the new level in the next cycle.
- R8: The interrupt outputs ignore bus writes, including writes that copy a value into bit 1. They also ignore updates that leave the byte unchanged, so a line can keep a value that differs from the stored bit.
- R9: In the cycle after `nmi_req`, pin 9's bit 1 and `irq_follow` are both 1. In the cycle after that, both are 0 unless `nmi_req` is given again. While this pulse is in progress, it overrides pin updates to pin 9.
- R10: `pin_err` is 1 for the one cycle after an update to a pin whose stored output-enable bit was 1 before that update. The update is still applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe for `bus_wdata` at `bus_addr` |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_upd_valid | input | 1 | Pin-level update request |
| pin_upd_sel | input | 6 | Index of the pin being updated |
| pin_upd_level | input | 1 | New input level for the selected pin |
| nmi_req | input | 1 | One-cycle non-maskable pulse request |
| irq_lowlvl | output | 1 | Pin 1 interrupt, high while asserted |
| irq_follow | output | 1 | Pin 9 interrupt, follows its input |
| pin_err | output | 1 | One-cycle flag: update hit a pin configured as an output |

## Verification
The bench uses the default parameters: 36 pins, 8 level bytes, a 6-bit offset, the level-low source on pin 1 and the follower on pin 9. The 6-bit offset and the 6-bit update index both reach past the mapped range, so the reads and writes that must return zero or be ignored, and the out-of-range updates, all occur naturally. The bench also drives cases that stress the interplay: bus writes and updates to the same pin in one cycle, non-maskable requests that land during a pin 9 update, and interrupt lines that stop matching the stored input bit.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    // Per-pin control byte; bit order is decoded by software.
    typedef struct packed {
        logic [4:0] spare;
        logic       oe;       // bit 2
        logic       in_lvl;   // bit 1
        logic       out_val;  // bit 0
    } pin_ctrl_t;

    typedef enum logic [1:0] {
        REGION_LEVEL = 2'd0,
        REGION_PIN   = 2'd1,
        REGION_NONE  = 2'd2
    } region_e;

    // Merge a bus write into a control byte: bit 1 of the data is dropped,
    // and the input bit tracks the output value only when driving.
    function automatic pin_ctrl_t apply_write(pin_ctrl_t cur, logic [7:0] data);
        pin_ctrl_t r;
        r        = pin_ctrl_t'(data);
        r.in_lvl = data[2] ? data[0] : cur.in_lvl;
        return r;
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int NUM_LVL   = 8,
    parameter int NUM_PINS  = 36,
    parameter int IDX_W     = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W-1:0] PIN_BASE = ADDR_W'(NUM_LVL);
    localparam logic [ADDR_W-1:0] PIN_END  = ADDR_W'(NUM_LVL + NUM_PINS);

    logic [ADDR_W-1:0] rel;

    always_comb begin
        rel    = addr - PIN_BASE;
        region = REGION_NONE;
        idx    = '0;
        if (addr < PIN_BASE) begin
            region = REGION_LEVEL;
        end else if (addr < PIN_END) begin
            region = REGION_PIN;
            idx    = IDX_W'(rel);
        end
    end
endmodule

// File: rtl/gpio_pin_bank.sv
module gpio_pin_bank
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 36,
    parameter int IDX_W    = 6,
    parameter int LVL_PIN  = 1,
    parameter int EDGE_PIN = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_hit,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic             upd_hit,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_level,
    input  logic             nmi_set,
    input  logic             nmi_clr,
    output pin_ctrl_t        regs_q [NUM_PINS],
    output logic             lvl_ev,
    output logic             edge_ev,
    output logic             conflict
);
    logic [NUM_PINS-1:0] mid_in;
    logic [NUM_PINS-1:0] oe_q;
    logic [NUM_PINS-1:0] in_q;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        pin_ctrl_t q, mid, nxt;
        logic      wr_me, upd_me;

        assign wr_me  = wr_hit  && (wr_idx  == IDX_W'(g));
        assign upd_me = upd_hit && (upd_idx == IDX_W'(g));

        always_comb begin
            mid = wr_me ? apply_write(q, wr_data) : q;
            nxt = mid;
            if (upd_me) nxt.in_lvl = upd_level;
            if (g == EDGE_PIN) begin
                if (nmi_set)      nxt.in_lvl = 1'b1;
                else if (nmi_clr) nxt.in_lvl = 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                q        <= '0;
                q.in_lvl <= (g == LVL_PIN);
            end else begin
                q <= nxt;
            end
        end

        assign regs_q[g] = q;
        assign mid_in[g] = mid.in_lvl;
        assign oe_q[g]   = q.oe;
        assign in_q[g]   = q.in_lvl;

        AST_WRITE_MIRROR: assert property (@(posedge clk) disable iff (rst)
            (wr_me && wr_data[2] && !upd_me && !((g == EDGE_PIN) && (nmi_set || nmi_clr)))
            |=> (q.in_lvl == $past(wr_data[0])))
            else $error("write with output enable did not mirror value"); // R4
    end

    // Interrupt events: only an update that changes the merged byte counts.
    assign lvl_ev   = upd_hit && (upd_idx == IDX_W'(LVL_PIN)) && (mid_in[LVL_PIN] != upd_level);
    assign edge_ev  = upd_hit && (upd_idx == IDX_W'(EDGE_PIN)) && (mid_in[EDGE_PIN] != upd_level)
                      && !nmi_set && !nmi_clr;
    assign conflict = upd_hit && oe_q[upd_idx];

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr_hit && !upd_hit && !nmi_set && !nmi_clr) |=> ($stable(oe_q) && $stable(in_q)))
        else $error("control bytes moved with no request"); // R3

    AST_UPD_APPLIED: assert property (@(posedge clk) disable iff (rst)
        (upd_hit && !nmi_set && !nmi_clr) |=> (in_q[$past(upd_idx)] == $past(upd_level)))
        else $error("pin update not applied"); // R5
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route (
    input  logic clk,
    input  logic rst,
    input  logic nmi_req,
    input  logic lvl_ev,
    input  logic edge_ev,
    input  logic upd_level,
    input  logic conflict,
    output logic nmi_set,
    output logic nmi_clr,
    output logic irq_lowlvl,
    output logic irq_follow,
    output logic pin_err
);
    logic tail_q;

    assign nmi_set = nmi_req;
    assign nmi_clr = tail_q && !nmi_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            tail_q     <= 1'b0;
            irq_lowlvl <= 1'b0;
            irq_follow <= 1'b0;
            pin_err    <= 1'b0;
        end else begin
            tail_q  <= nmi_req;
            pin_err <= conflict;
            if (lvl_ev) irq_lowlvl <= !upd_level;
            if (nmi_set)      irq_follow <= 1'b1;
            else if (nmi_clr) irq_follow <= 1'b0;
            else if (edge_ev) irq_follow <= upd_level;
        end
    end

    AST_NMI_RAISE: assert property (@(posedge clk) disable iff (rst)
        nmi_req |=> irq_follow)
        else $error("nmi did not raise follower line"); // R9
    AST_NMI_DROP: assert property (@(posedge clk) disable iff (rst)
        (tail_q && !nmi_req) |=> !irq_follow)
        else $error("nmi pulse longer than one cycle"); // R9
    AST_LVL_QUIET: assert property (@(posedge clk) disable iff (rst)
        !lvl_ev |=> $stable(irq_lowlvl))
        else $error("level line moved without a changing update"); // R8
    AST_LVL_POLARITY: assert property (@(posedge clk) disable iff (rst)
        lvl_ev |=> (irq_lowlvl == !$past(upd_level)))
        else $error("level line polarity wrong"); // R6
    AST_ERR_SOURCE: assert property (@(posedge clk) disable iff (rst)
        pin_err |-> $past(conflict))
        else $error("error flag without conflicting update"); // R10
endmodule

// File: rtl/gpio_byte_ctrl.sv
module gpio_byte_ctrl
    import gpio_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int NUM_LVL  = 8,
    parameter int NUM_PINS = 36,
    parameter int LVL_PIN  = 1,
    parameter int EDGE_PIN = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              pin_upd_valid,
    input  logic [ADDR_W-1:0] pin_upd_sel,
    input  logic              pin_upd_level,
    input  logic              nmi_req,
    output logic              irq_lowlvl,
    output logic              irq_follow,
    output logic              pin_err
);
    localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    region_e          region;
    logic [IDX_W-1:0] idx;
    pin_ctrl_t        regs_q [NUM_PINS];
    logic             wr_hit, upd_hit;
    logic [IDX_W-1:0] upd_idx;
    logic             lvl_ev, edge_ev, conflict, nmi_set, nmi_clr;

    gpio_addr_decode #(
        .ADDR_W(ADDR_W), .NUM_LVL(NUM_LVL), .NUM_PINS(NUM_PINS), .IDX_W(IDX_W)
    ) u_dec (
        .addr(bus_addr), .region(region), .idx(idx)
    );

    assign wr_hit  = bus_wr && (region == REGION_PIN);
    assign upd_hit = pin_upd_valid && (pin_upd_sel < ADDR_W'(NUM_PINS));
    assign upd_idx = IDX_W'(pin_upd_sel);

    gpio_pin_bank #(
        .NUM_PINS(NUM_PINS), .IDX_W(IDX_W), .LVL_PIN(LVL_PIN), .EDGE_PIN(EDGE_PIN)
    ) u_bank (
        .clk(clk), .rst(rst),
        .wr_hit(wr_hit), .wr_idx(idx), .wr_data(bus_wdata),
        .upd_hit(upd_hit), .upd_idx(upd_idx), .upd_level(pin_upd_level),
        .nmi_set(nmi_set), .nmi_clr(nmi_clr),
        .regs_q(regs_q), .lvl_ev(lvl_ev), .edge_ev(edge_ev), .conflict(conflict)
    );

    gpio_irq_route u_irq (
        .clk(clk), .rst(rst), .nmi_req(nmi_req),
        .lvl_ev(lvl_ev), .edge_ev(edge_ev), .upd_level(pin_upd_level),
        .conflict(conflict), .nmi_set(nmi_set), .nmi_clr(nmi_clr),
        .irq_lowlvl(irq_lowlvl), .irq_follow(irq_follow), .pin_err(pin_err)
    );

    // Level bytes carry no source and read as zero.
    always_comb begin
        bus_rdata = 8'h00;
        if (region == REGION_PIN) bus_rdata = regs_q[idx];
    end

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq_lowlvl && !irq_follow && !pin_err && regs_q[LVL_PIN].in_lvl))
        else $error("reset state wrong"); // R1
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (region != REGION_PIN) |-> (bus_rdata == 8'h00))
        else $error("unmapped read not zero"); // R2
endmodule

// File: tb/sim_gpio_byte_ctrl.sv
module sim_gpio_byte_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       pin_upd_valid = 1'b0;
    logic [5:0] pin_upd_sel = '0;
    logic       pin_upd_level = 1'b0;
    logic       nmi_req = 1'b0;
    logic       irq_lowlvl, irq_follow, pin_err;

    int checks = 0;
    int failures = 0;

    // reference model state
    int m_reg [36];
    bit m_lvl, m_edge, m_err, m_tail;

    always #4 clk = ~clk;   // 125 MHz

    gpio_byte_ctrl u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_upd_valid(pin_upd_valid), .pin_upd_sel(pin_upd_sel),
        .pin_upd_level(pin_upd_level), .nmi_req(nmi_req),
        .irq_lowlvl(irq_lowlvl), .irq_follow(irq_follow), .pin_err(pin_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int model_read(input int a);
        if (a >= 8 && a < 44) return m_reg[a - 8];
        return 0;
    endfunction

    task automatic model_reset();
        foreach (m_reg[i]) m_reg[i] = 0;
        m_reg[1] = 2;
        m_lvl = 0; m_edge = 0; m_err = 0; m_tail = 0;
    endtask

    task automatic model_step(input bit wr, input int a, input int wd,
                              input bit uv, input int ui, input bit ul, input bit nmi);
        bit nmi_clr = m_tail && !nmi;
        m_err = uv && ui < 36 && ((m_reg[ui] & 4) != 0);
        if (wr && a >= 8 && a < 44) begin
            int d = wd & 'hFD;
            int in_b = ((d & 4) != 0) ? (d & 1) : ((m_reg[a - 8] >> 1) & 1);
            m_reg[a - 8] = d | (in_b << 1);
        end
        if (uv && ui < 36) begin
            int nb = (m_reg[ui] & 'hFD) | (int'(ul) << 1);
            if (nb != m_reg[ui]) begin
                if (ui == 1) m_lvl = !ul;
                if (ui == 9 && !nmi && !nmi_clr) m_edge = ul;
            end
            m_reg[ui] = nb;
        end
        if (nmi) begin
            m_reg[9] = m_reg[9] | 2; m_edge = 1;
        end else if (nmi_clr) begin
            m_reg[9] = m_reg[9] & 'hFD; m_edge = 0;
        end
        m_tail = nmi;
    endtask

    task automatic cyc(input bit wr, input int a, input int wd,
                       input bit uv, input int ui, input bit ul, input bit nmi);
        bus_wr = wr; bus_addr = 6'(a); bus_wdata = 8'(wd);
        pin_upd_valid = uv; pin_upd_sel = 6'(ui); pin_upd_level = ul; nmi_req = nmi;
        model_step(wr, a, wd, uv, ui, ul, nmi);
        @(posedge clk);
        @(negedge clk);
        bus_wr = 0; pin_upd_valid = 0; nmi_req = 0;
        chk(irq_lowlvl == m_lvl, "R6 irq_lowlvl", int'(irq_lowlvl), int'(m_lvl));
        chk(irq_follow == m_edge, "R7 irq_follow", int'(irq_follow), int'(m_edge));
        chk(pin_err == m_err, "R10 pin_err", int'(pin_err), int'(m_err));
    endtask

    task automatic rd(input int a, input string req);
        bus_wr = 0; bus_addr = 6'(a);
        #1;
        chk(int'(bus_rdata) == model_read(a), req, int'(bus_rdata), model_read(a));
    endtask

    task automatic rd_all(input string req);
        for (int a = 0; a < 64; a++) rd(a, req);
    endtask

    initial begin
        #(8 * 150000);
        failures++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset state
        chk(irq_lowlvl == 0 && irq_follow == 0 && pin_err == 0, "R1 outputs",
            int'({irq_lowlvl, irq_follow, pin_err}), 0);
        rd(9, "R1 pin1 default");
        rd_all("R2 reset readback");

        // R3 writes to level and unmapped offsets ignored
        for (int a = 0; a < 8; a++) cyc(1, a, 'hFF, 0, 0, 0, 0);
        for (int a = 44; a < 64; a++) cyc(1, a, 'hFF, 0, 0, 0, 0);
        rd_all("R3 ignored writes");

        // R4 write merge
        cyc(1, 11, 'h01, 0, 0, 0, 0); rd(11, "R4 out value only");
        cyc(1, 12, 'h03, 0, 0, 0, 0); rd(12, "R4 bit1 discarded");
        cyc(1, 13, 'h05, 0, 0, 0, 0); rd(13, "R4 mirror high");
        cyc(1, 13, 'h04, 0, 0, 0, 0); rd(13, "R4 mirror low");
        cyc(1, 14, 'hFA, 0, 0, 0, 0); rd(14, "R4 upper bits kept");
        cyc(1, 15, 'h05, 0, 0, 0, 0); cyc(1, 15, 'h00, 0, 0, 0, 0);
        rd(15, "R4 input kept when not driving");

        // R5 pin updates
        cyc(0, 0, 0, 1, 3, 1, 0); rd(11, "R5 update bit1 only");
        cyc(0, 0, 0, 1, 40, 1, 0); rd_all("R5 out of range ignored");
        cyc(1, 16, 'h05, 1, 8, 0, 0); rd(16, "R5 update after write");

        // R6 level-low line
        cyc(0, 0, 0, 1, 1, 0, 0);
        chk(irq_lowlvl == 1, "R6 asserted on low", int'(irq_lowlvl), 1);
        cyc(0, 0, 0, 1, 1, 0, 0);
        cyc(0, 0, 0, 1, 1, 1, 0);
        chk(irq_lowlvl == 0, "R6 released on high", int'(irq_lowlvl), 0);

        // R8 writes that mirror do not move the line
        cyc(1, 9, 'h04, 0, 0, 0, 0); rd(9, "R8 mirrored input");
        chk(irq_lowlvl == 0, "R8 write leaves line", int'(irq_lowlvl), 0);
        cyc(0, 0, 0, 1, 1, 0, 0);
        chk(irq_lowlvl == 0, "R8 unchanged byte no action", int'(irq_lowlvl), 0);
        chk(pin_err == 1, "R10 update to output pin", int'(pin_err), 1);
        cyc(0, 0, 0, 1, 1, 1, 0);
        cyc(0, 0, 0, 1, 1, 0, 0);
        chk(irq_lowlvl == 1, "R8 resync after change", int'(irq_lowlvl), 1);
        cyc(1, 9, 'h00, 1, 1, 1, 0);

        // R7 follower line
        cyc(0, 0, 0, 1, 9, 1, 0);
        chk(irq_follow == 1, "R7 follows high", int'(irq_follow), 1);
        cyc(0, 0, 0, 1, 9, 0, 0);
        chk(irq_follow == 0, "R7 follows low", int'(irq_follow), 0);

        // R9 nmi pulse
        cyc(0, 0, 0, 0, 0, 0, 1);
        chk(irq_follow == 1, "R9 pulse high", int'(irq_follow), 1);
        rd(17, "R9 pin9 input high");
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk(irq_follow == 0, "R9 pulse one cycle", int'(irq_follow), 0);
        rd(17, "R9 pin9 input low");
        cyc(0, 0, 0, 1, 9, 0, 1);
        cyc(0, 0, 0, 1, 9, 1, 0);
        chk(irq_follow == 0, "R9 overrides update", int'(irq_follow), 0);
        cyc(0, 0, 0, 0, 0, 0, 0);

        // R10 conflict still applies update
        cyc(0, 0, 0, 1, 5, 1, 0);
        rd(13, "R10 update applied");
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk(pin_err == 0, "R10 one cycle", int'(pin_err), 0);

        // mixed traffic against the model
        for (int n = 0; n < 600; n++) begin
            int sel = $urandom_range(0, 3);
            int ui  = (sel == 0) ? 1 : (sel == 1) ? 9 : $urandom_range(0, 63);
            int a   = $urandom_range(0, 63);
            cyc($urandom_range(0, 1), ($urandom_range(0, 2) == 0) ? 9 + 8 * sel[0] : a,
                $urandom_range(0, 255), $urandom_range(0, 1), ui,
                $urandom_range(0, 1), ($urandom_range(0, 9) == 0));
            rd($urandom_range(0, 63), "R2 random readback");
        end
        cyc(0, 0, 0, 0, 0, 0, 0);
        rd_all("R4 final readback");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule